// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block is a watchdog that counts slow timing ticks and raises a reset request when software has not restarted it within a set time. Each tick is one cycle of a low-frequency tick enable derived from a low-power RC clock and presented on `tick`. A base divider turns `BASE_DIV` ticks into one nominal base period, nominally 4 ms. A power-of-two postscaler then counts base periods, and the ratio is picked by a 4-bit select. The longest setting is 32768 base periods, or 131.072 s at the nominal base period.

Two inputs decide whether the watchdog runs. A fixed configuration enable forces it on whatever software does. When that enable is low, a software-writable enable bit turns it on and off. Software restarts the count by pulsing `clr`. On expiry the block emits a one-cycle `rst_req` pulse for the chip's reset logic, and counting starts again from zero.

Top module: `wdog_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rst_req` is 0.
- R2: With `cfg_en` = 1 the watchdog runs whatever the value of `sw_en`.
- R3: With `cfg_en` = 0 the watchdog runs only while `sw_en` = 1. With both enables low, `rst_req` never asserts.
- R4: For select value n (0 to 15) on `ps_sel`, `rst_req` asserts once `BASE_DIV` × 2^n ticks have been counted since the last restart. It goes high in the cycle after the clock edge that samples the last of those ticks.
- R5: Only cycles with `tick` = 1 advance the count. Idle cycles between ticks do not change when `rst_req` fires in terms of ticks.
- R6: A `clr` pulse zeroes the base divider and the postscaler, so a full `BASE_DIV` × 2^n ticks follow before the next `rst_req`.
- R7: `rst_req` is high for exactly one cycle per expiry. The counters restart at expiry, and the next pulse follows after another full timeout.
- R8: While the watchdog is disabled both counters are held at zero. Re-enabling it starts a full timeout.
- R9: When `clr` and `tick` are both high in the same cycle, the clear wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per slow-clock period |
| cfg_en | input | 1 | Fixed configuration enable; forces the watchdog on |
| sw_en | input | 1 | Software enable, used when `cfg_en` is 0 |
| ps_sel | input | 4 | Postscale select n, ratio 2^n |
| clr | input | 1 | Restart strobe from software |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench counts the exact number of ticks to expiry at several select values, including ratio 1 and a large ratio. An off-by-one in the divider or the postscaler compare would move the pulse by one tick or by a whole base period. It clears mid-count, with and without a tick in the same cycle, and toggles the software enable mid-count. A design that kept partial counts, or that counted the colliding tick, would fire early. Runs with sparse ticks and runs of back-to-back expiries catch counting on idle cycles, pulses longer than one cycle, and counters that are not restarted after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned POST_W = (1 << SEL_W) - 1;
  typedef logic [SEL_W-1:0]  ps_sel_t;
  typedef logic [POST_W-1:0] post_cnt_t;
endpackage

// File: rtl/wdog_enable.sv
module wdog_enable (
  input  logic cfg_en,
  input  logic sw_en,
  output logic run
);
  // the fixed configuration bit overrides the software bit
  always_comb run = cfg_en ? 1'b1 : sw_en;
endmodule

// File: rtl/wdog_base_div.sv
module wdog_base_div #(
  parameter int unsigned BASE_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic wrap,
  output logic [$clog2(BASE_DIV+1)-1:0] cnt_q
);
  localparam int unsigned CW = $clog2(BASE_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(BASE_DIV - 1);

  always_comb wrap = run & ~clr & tick & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) cnt_q <= '0;
    else if (wrap)             cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_post.sv
module wdog_post
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      clr,
  input  logic      step,
  input  ps_sel_t   sel,
  output logic      expire,
  output post_cnt_t cnt_q
);
  post_cnt_t lim_m1;

  always_comb begin
    lim_m1 = post_cnt_t'((32'd1 << sel) - 32'd1);
    // >= so that lowering the select mid-count still expires
    expire = step & (cnt_q >= lim_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) cnt_q <= '0;
    else if (expire)           cnt_q <= '0;
    else if (step)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_en,
  input  logic       sw_en,
  input  logic [3:0] ps_sel,
  input  logic       clr,
  output logic       rst_req
);
  localparam int unsigned CW = $clog2(BASE_DIV + 1);

  logic          run;
  logic          base_wrap;
  logic          expire;
  logic [CW-1:0] base_cnt;
  post_cnt_t     post_cnt;

  wdog_enable u_en (
    .cfg_en (cfg_en),
    .sw_en  (sw_en),
    .run    (run)
  );

  wdog_base_div #(.BASE_DIV(BASE_DIV)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (clr),
    .tick  (tick),
    .wrap  (base_wrap),
    .cnt_q (base_cnt)
  );

  wdog_post u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .clr    (clr),
    .step   (base_wrap),
    .sel    (ps_sel_t'(ps_sel)),
    .expire (expire),
    .cnt_q  (post_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire;
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned CW = 8,
  parameter int unsigned PW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cfg_en,
  input logic          sw_en,
  input logic          clr,
  input logic          rst_req,
  input logic [CW-1:0] base_q,
  input logic [PW-1:0] post_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rst_req);
  // R3
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !sw_en) |=> !rst_req);
  // R5
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !rst_req);
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (base_q == '0 && post_q == '0));
  // R9
  clr_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rst_req);
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !sw_en) |=> (base_q == '0 && post_q == '0));
endmodule

bind wdog_core wdog_chk #(.CW(CW), .PW(wdog_pkg::POST_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .cfg_en  (cfg_en),
  .sw_en   (sw_en),
  .clr     (clr),
  .rst_req (rst_req),
  .base_q  (base_cnt),
  .post_q  (post_cnt)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;
  localparam int BD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cfg_en = 1'b0, sw_en = 1'b0, clr = 1'b0;
  logic [3:0] ps_sel = 4'd0;
  logic rst_req;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wdog_core #(.BASE_DIV(BD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_en(cfg_en), .sw_en(sw_en),
    .ps_sel(ps_sel), .clr(clr), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clear cycle with tick low, ends at a negedge
  task automatic restart();
    tick = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // ticks once per 'period' cycles until rst_req, returns ticks counted
  task automatic ticks_to_req(input int period, input int limit, output int n);
    int cyc = 0;
    n = 0;
    while (!rst_req && cyc < limit) begin
      tick = (cyc % period) == 0;
      if (tick) n++;
      cyc++;
      @(negedge clk);
    end
    tick = 1'b0;
    if (!rst_req) n = -1;
  endtask

  // k ticks, one per cycle, returns how many cycles showed rst_req
  task automatic tick_k(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (rst_req) seen++;
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rst_req low in reset", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst_req low after reset", int'(rst_req), 0);
  endtask

  task automatic t_ratio();
    int n;
    cfg_en = 1'b1; sw_en = 1'b0;
    ps_sel = 4'd0; restart(); ticks_to_req(1, 5000, n);
    check("R2/R4 sel0 forced by cfg_en", n, BD);
    ps_sel = 4'd1; restart(); ticks_to_req(1, 5000, n);
    check("R4 sel1", n, BD * 2);
    ps_sel = 4'd3; restart(); ticks_to_req(1, 5000, n);
    check("R4 sel3", n, BD * 8);
    ps_sel = 4'd8; restart(); ticks_to_req(1, 20000, n);
    check("R4 sel8", n, BD * 256);
  endtask

  task automatic t_sw_enable();
    int n, seen;
    cfg_en = 1'b0; sw_en = 1'b1; ps_sel = 4'd2;
    restart(); ticks_to_req(1, 5000, n);
    check("R3 sw_en runs", n, BD * 4);
    sw_en = 1'b0; restart();
    tick_k(200, seen);
    check("R3 both off never fires", seen, 0);
  endtask

  task automatic t_sparse();
    int n;
    cfg_en = 1'b1; ps_sel = 4'd1; restart();
    ticks_to_req(3, 5000, n);
    check("R5 sparse ticks counted", n, BD * 2);
  endtask

  task automatic t_clear();
    int n, seen;
    cfg_en = 1'b1; ps_sel = 4'd2; restart();
    tick_k(10, seen);
    check("R6 no early fire", seen, 0);
    restart();
    ticks_to_req(1, 5000, n);
    check("R6 full timeout after clr", n, BD * 4);
  endtask

  task automatic t_clr_tick();
    int n, seen;
    cfg_en = 1'b1; ps_sel = 4'd2; restart();
    tick_k(10, seen);
    tick = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; tick = 1'b0;
    ticks_to_req(1, 5000, n);
    check("R9 clr beats tick", n, BD * 4);
  endtask

  task automatic t_disable();
    int n, seen;
    cfg_en = 1'b0; sw_en = 1'b1; ps_sel = 4'd2; restart();
    tick_k(10, seen);
    sw_en = 1'b0;
    tick_k(5, seen);
    check("R8 disabled no fire", seen, 0);
    sw_en = 1'b1;
    ticks_to_req(1, 5000, n);
    check("R8 full timeout after re-enable", n, BD * 4);
  endtask

  task automatic t_repeat();
    int n;
    cfg_en = 1'b1; ps_sel = 4'd1; restart();
    ticks_to_req(1, 5000, n);
    check("R7 first expiry", n, BD * 2);
    tick = 1'b1;
    @(negedge clk);
    check("R7 pulse one cycle", int'(rst_req), 0);
    ticks_to_req(1, 5000, n);
    check("R7 restart after expiry", n, BD * 2 - 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ratio();
        t_sw_enable();
        t_sparse();
        t_clear();
        t_clr_tick();
        t_disable();
        t_repeat();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule